// File: doc/BRIEF.md
# Hardware Spinlock Register Bank

This block is a bank of hardware mutual-exclusion flags that several bus requesters share. Each flag sits in its own 32-bit word. A requester acquires a flag with one ordinary read. If the read returns 0, the flag was free and now belongs to that requester. If it returns 1, another requester holds it and the attempt failed. The owner gives the flag back by writing 0. Software therefore needs no atomic read-modify-write instruction to build a lock.

Every requester has its own address, read strobe, write strobe, write data and read data. All of them reach the bank in the same cycle. Read data is combinational within the cycle of the strobe, and a state change takes effect at the following clock edge. When several requesters read the same free flag in one cycle, a fixed priority hands it to the lowest-numbered one. A read-only status word reports the bank size as a one-hot multiple of 32.

The bank size is a parameter of 32, 64, 128 or 256 flags. The status field is derived from it. The asynchronous active-low reset is released synchronously inside the block, two clock edges after `rst_n` rises.

Top module: `hwlock_bank`

## Requirements
- R1: After reset every flag reads as free (0), including a flag that was held when reset was asserted.
- R2: A read of a free flag returns 0 and takes it, so the next read of that flag returns 1.
- R3: A read of a held flag returns 1 and leaves it held.
- R4: Writing the value 0 to a held flag frees it, so the next read of it returns 0.
- R5: Writing any nonzero value to a flag leaves it unchanged.
- R6: Flag i lives at byte address 0x800 + 4*i, and each flag changes state independently of the others.
- R7: A read of byte address 0x014 returns the flag count divided by 32 in bits 27:24, with zeros elsewhere. That field is one-hot: 1, 2, 4 or 8.
- R8: When several requesters read the same free flag in one cycle, only the lowest-numbered one reads 0 and takes it. The others read 1.
- R9: Reads of any other address return 0, and writes to it change nothing. This covers addresses beyond the last flag, misaligned flag addresses and other offsets.
- R10: A requester's read data is 0 in any cycle in which its read strobe is low.
- R11: A write of 0 and a read of the same flag by different requesters in one cycle behave as follows. The reader sees the flag's state from before that cycle. If the flag was free, the reader takes it. Otherwise the flag ends up free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | NUM_REQ*ADDR_W | Byte address per requester; requester k uses slice k |
| bus_rd | input | NUM_REQ | Read strobe per requester |
| bus_wr | input | NUM_REQ | Write strobe per requester |
| bus_wdata | input | NUM_REQ*32 | Write data per requester |
| bus_rdata | output | NUM_REQ*32 | Read data per requester, valid in the strobe cycle |

## Verification
The bench builds the bank with 64 flags and three requesters. With 64 flags, the status field holds a value other than the minimum, and the address 0x900 lies just past the last flag while still inside the decoded window. With three requesters, a three-way collision on one flag can occur, and a collision between the two lower-priority requesters can occur while the highest-priority one is idle. The bench also covers a release and an acquire attempt on the same flag in one cycle, as well as a reset taken while a flag is held.

// File: rtl/hwlock_pkg.sv
`timescale 1ns/1ps
package hwlock_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned LOCK_BASE  = 32'h0000_0800;
  localparam int unsigned STATUS_OFF = 32'h0000_0014;
  localparam int unsigned CNT_LSB    = 24;
  localparam int unsigned LOCK_UNIT  = 32;

  function automatic logic count_ok(input int unsigned n);
    return (n == 32) || (n == 64) || (n == 128) || (n == 256);
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input int unsigned n);
    return DATA_W'(n / LOCK_UNIT) << CNT_LSB;
  endfunction
endpackage

// File: rtl/hwlock_decode.sv
`timescale 1ns/1ps
module hwlock_decode
  import hwlock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_lock,
  output logic              is_status,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned LOCK_END = LOCK_BASE + 4 * NUM_LOCKS;

  logic [31:0] byte_addr;

  always_comb begin
    byte_addr = 32'(addr);
    is_lock   = (byte_addr >= LOCK_BASE) && (byte_addr < LOCK_END) &&
                (byte_addr[1:0] == 2'b00);
    is_status = (byte_addr == STATUS_OFF);
    idx       = IDX_W'((byte_addr - LOCK_BASE) >> 2);
  end
endmodule

// File: rtl/hwlock_arb.sv
`timescale 1ns/1ps
module hwlock_arb #(
  parameter int unsigned NUM_REQ = 2
) (
  input  logic [NUM_REQ-1:0] want,
  output logic [NUM_REQ-1:0] grant
);
  always_comb begin
    grant = '0;
    for (int k = 0; k < NUM_REQ; k++) begin
      if (want[k] && (grant == '0)) grant[k] = 1'b1;
    end
  end
endmodule

// File: rtl/hwlock_cell.sv
`timescale 1ns/1ps
module hwlock_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic rel_i,
  output logic taken_q
);
  logic taken_d;
  logic taken_en;

  always_comb begin
    taken_en = take | rel_i;
    taken_d  = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        taken_q <= 1'b0;
    else if (taken_en) taken_q <= taken_d;
  end
endmodule

// File: rtl/hwlock_bank.sv
`timescale 1ns/1ps
module hwlock_bank
  import hwlock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned NUM_REQ   = 2,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REQ*ADDR_W-1:0]  bus_addr,
  input  logic [NUM_REQ-1:0]         bus_rd,
  input  logic [NUM_REQ-1:0]         bus_wr,
  input  logic [NUM_REQ*DATA_W-1:0]  bus_wdata,
  output logic [NUM_REQ*DATA_W-1:0]  bus_rdata
);
  localparam int unsigned IDX_W = $clog2(NUM_LOCKS);
  localparam logic [DATA_W-1:0] STATUS_WORD = status_word(NUM_LOCKS);

  if (!count_ok(NUM_LOCKS)) begin : g_bad_count
    $error("hwlock_bank: NUM_LOCKS must be 32, 64, 128 or 256");
  end

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  // per-requester address decode
  logic [NUM_REQ-1:0] is_lock;
  logic [NUM_REQ-1:0] is_stat;
  logic [NUM_REQ-1:0] rd_lock;
  logic [NUM_REQ-1:0] wr_rel;
  logic [IDX_W-1:0]   idx [NUM_REQ];

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_req
    hwlock_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_LOCKS(NUM_LOCKS),
      .IDX_W    (IDX_W)
    ) u_dec (
      .addr     (bus_addr[k*ADDR_W +: ADDR_W]),
      .is_lock  (is_lock[k]),
      .is_status(is_stat[k]),
      .idx      (idx[k])
    );
    assign rd_lock[k] = bus_rd[k] & is_lock[k];
    assign wr_rel[k]  = bus_wr[k] & is_lock[k] &
                        (bus_wdata[k*DATA_W +: DATA_W] == '0);
  end

  // per-lock arbitration and state
  logic [NUM_LOCKS-1:0] lock_q;
  logic [NUM_REQ-1:0]   grant_mat [NUM_LOCKS];

  for (genvar j = 0; j < NUM_LOCKS; j++) begin : g_lock
    logic [NUM_REQ-1:0] want;
    logic [NUM_REQ-1:0] rel;

    always_comb begin
      for (int k = 0; k < NUM_REQ; k++) begin
        want[k] = rd_lock[k] && (idx[k] == IDX_W'(j)) && !lock_q[j];
        rel[k]  = wr_rel[k]  && (idx[k] == IDX_W'(j));
      end
    end

    hwlock_arb #(.NUM_REQ(NUM_REQ)) u_arb (
      .want (want),
      .grant(grant_mat[j])
    );

    hwlock_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .take   (|grant_mat[j]),
      .rel_i  (|rel),
      .taken_q(lock_q[j])
    );
  end

  // which requesters won a lock this cycle
  logic [NUM_REQ-1:0] won;

  always_comb begin
    won = '0;
    for (int j = 0; j < NUM_LOCKS; j++) won = won | grant_mat[j];
  end

  // read data
  for (genvar k = 0; k < NUM_REQ; k++) begin : g_rdata
    logic [DATA_W-1:0] rd_word;

    always_comb begin
      rd_word = '0;
      if (bus_rd[k] && is_stat[k]) rd_word = STATUS_WORD;
      else if (rd_lock[k])         rd_word = {{(DATA_W-1){1'b0}}, ~won[k]};
    end

    assign bus_rdata[k*DATA_W +: DATA_W] = rd_word;
  end
endmodule

// File: rtl/hwlock_bank_chk.sv
`timescale 1ns/1ps
module hwlock_bank_chk #(
  parameter int unsigned NUM_LOCKS = 32,
  parameter int unsigned NUM_REQ   = 2,
  parameter int unsigned ADDR_W    = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_REQ*ADDR_W-1:0] bus_addr,
  input logic [NUM_REQ-1:0]        bus_rd,
  input logic [NUM_REQ-1:0]        bus_wr,
  input logic [NUM_REQ*32-1:0]     bus_wdata,
  input logic [NUM_REQ*32-1:0]     bus_rdata,
  input logic [NUM_LOCKS-1:0]      lock_q
);
  localparam int unsigned IW = $clog2(NUM_LOCKS);
  localparam logic [31:0] EXP_STATUS = 32'(NUM_LOCKS / 32) << 24;

  function automatic logic flag_addr(input logic [ADDR_W-1:0] a);
    logic [31:0] w;
    w = 32'(a);
    return (w >= 32'h800) && (w < 32'h800 + 4 * NUM_LOCKS) && (w[1:0] == 2'b00);
  endfunction

  function automatic logic [IW-1:0] flag_idx(input logic [ADDR_W-1:0] a);
    return IW'((32'(a) - 32'h800) >> 2);
  endfunction

  logic [NUM_REQ-1:0] rel_clean;

  always_comb begin
    for (int k = 0; k < NUM_REQ; k++) begin
      rel_clean[k] = bus_wr[k] && flag_addr(bus_addr[k*ADDR_W +: ADDR_W]) &&
                     (bus_wdata[k*32 +: 32] == 32'h0);
      for (int m = 0; m < NUM_REQ; m++) begin
        if (bus_rd[m] && (bus_addr[m*ADDR_W +: ADDR_W] == bus_addr[k*ADDR_W +: ADDR_W]))
          rel_clean[k] = 1'b0;
      end
    end
  end

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_k
    logic [ADDR_W-1:0] a_k;
    logic [31:0]       d_k;
    logic              fl_k;
    logic [IW-1:0]     ix_k;
    assign a_k  = bus_addr[k*ADDR_W +: ADDR_W];
    assign d_k  = bus_rdata[k*32 +: 32];
    assign fl_k = flag_addr(a_k);
    assign ix_k = flag_idx(a_k);

    assert_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd[k] && fl_k && d_k == 32'h0) |=> lock_q[$past(ix_k)]);

    assert_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd[k] && fl_k && lock_q[ix_k]) |-> (d_k == 32'h1));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rel_clean[k] |=> !lock_q[$past(ix_k)]);

    assert_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd[k] && 32'(a_k) == 32'h14) |-> (d_k == EXP_STATUS && $onehot(d_k[27:24])));

    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd[k] && !fl_k && 32'(a_k) != 32'h14) |-> (d_k == 32'h0));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd[k] |-> (d_k == 32'h0));

    for (genvar m = k + 1; m < NUM_REQ; m++) begin : g_m
      assert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd[k] && bus_rd[m] && fl_k && (a_k == bus_addr[m*ADDR_W +: ADDR_W]))
          |-> !(d_k == 32'h0 && bus_rdata[m*32 +: 32] == 32'h0));
    end
  end
endmodule

bind hwlock_bank hwlock_bank_chk #(
  .NUM_LOCKS(NUM_LOCKS),
  .NUM_REQ  (NUM_REQ),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .lock_q   (lock_q)
);

// File: tb/hwlock_bank_tb_top.sv
`timescale 1ns/1ps
module hwlock_bank_tb_top;
  localparam int unsigned NL = 64;
  localparam int unsigned NR = 3;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NR*AW-1:0]  bus_addr = '0;
  logic [NR-1:0]     bus_rd = '0;
  logic [NR-1:0]     bus_wr = '0;
  logic [NR*DW-1:0]  bus_wdata = '0;
  logic [NR*DW-1:0]  bus_rdata;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  hwlock_bank #(.NUM_LOCKS(NL), .NUM_REQ(NR), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic [1:0]  req;
    logic        rd;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  // one access per row; write rows expect read data 0 (R10)
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{req:2'd0, rd:1'b1, addr:12'h800, wdata:32'h0, exp:32'h0, rq:4'd2},   // R2 take
    '{req:2'd0, rd:1'b1, addr:12'h800, wdata:32'h0, exp:32'h1, rq:4'd2},   // R2 now held
    '{req:2'd1, rd:1'b1, addr:12'h800, wdata:32'h0, exp:32'h1, rq:4'd3},   // R3 other fails
    '{req:2'd2, rd:1'b0, addr:12'h800, wdata:32'h5, exp:32'h0, rq:4'd5},   // R5 nonzero write
    '{req:2'd1, rd:1'b1, addr:12'h800, wdata:32'h0, exp:32'h1, rq:4'd5},   // R5 still held
    '{req:2'd2, rd:1'b0, addr:12'h800, wdata:32'h0, exp:32'h0, rq:4'd4},   // R4 release
    '{req:2'd1, rd:1'b1, addr:12'h800, wdata:32'h0, exp:32'h0, rq:4'd4},   // R4 free again
    '{req:2'd0, rd:1'b1, addr:12'h8FC, wdata:32'h0, exp:32'h0, rq:4'd6},   // R6 last flag
    '{req:2'd0, rd:1'b1, addr:12'h804, wdata:32'h0, exp:32'h0, rq:4'd6},   // R6 flag 1
    '{req:2'd2, rd:1'b1, addr:12'h8FC, wdata:32'h0, exp:32'h1, rq:4'd6},   // R6 last held
    '{req:2'd1, rd:1'b1, addr:12'h014, wdata:32'h0, exp:32'h0200_0000, rq:4'd7}, // R7
    '{req:2'd0, rd:1'b1, addr:12'h900, wdata:32'h0, exp:32'h0, rq:4'd9},   // R9 past end
    '{req:2'd0, rd:1'b0, addr:12'h900, wdata:32'h0, exp:32'h0, rq:4'd9},   // R9 write
    '{req:2'd0, rd:1'b1, addr:12'h900, wdata:32'h0, exp:32'h0, rq:4'd9},   // R9 still 0
    '{req:2'd0, rd:1'b1, addr:12'h802, wdata:32'h0, exp:32'h0, rq:4'd9},   // R9 misaligned
    '{req:2'd2, rd:1'b1, addr:12'h010, wdata:32'h0, exp:32'h0, rq:4'd9},   // R9 other offset
    '{req:2'd1, rd:1'b1, addr:12'h804, wdata:32'h0, exp:32'h1, rq:4'd6}    // R6 flag 1 kept
  };

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic idle_all();
    bus_rd = '0; bus_wr = '0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic drive(input int k, input logic rd, input logic wr,
                       input logic [AW-1:0] a, input logic [31:0] d);
    bus_rd[k] = rd;
    bus_wr[k] = wr;
    bus_addr[k*AW +: AW] = a;
    bus_wdata[k*DW +: DW] = d;
  endtask

  function automatic logic [31:0] rdat(input int k);
    return bus_rdata[k*DW +: DW];
  endfunction

  function automatic logic [AW-1:0] faddr(input int i);
    return AW'(32'h800 + 4 * i);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: every flag free after reset (reading takes it)
    for (int i = 0; i < NL; i++) begin
      @(negedge clk); idle_all(); drive(0, 1'b1, 1'b0, faddr(i), 32'h0);
      #2 chk(1, rdat(0), 32'h0, "flag free after reset");
    end
    for (int i = 0; i < NL; i++) begin
      @(negedge clk); idle_all(); drive(1, 1'b0, 1'b1, faddr(i), 32'h0);
    end

    // vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk); idle_all();
      drive(int'(VEC[v].req), VEC[v].rd, !VEC[v].rd, VEC[v].addr, VEC[v].wdata);
      #2 chk(int'(VEC[v].rq), rdat(int'(VEC[v].req)), VEC[v].exp, "vector");
    end

    // R8: three-way collision on flag 10
    @(negedge clk); idle_all();
    for (int k = 0; k < NR; k++) drive(k, 1'b1, 1'b0, 12'h828, 32'h0);
    #2;
    chk(8, rdat(0), 32'h0, "collision r0 wins");
    chk(8, rdat(1), 32'h1, "collision r1 loses");
    chk(8, rdat(2), 32'h1, "collision r2 loses");

    // R8: r1 and r2 collide on flag 11, r0 idle (R10)
    @(negedge clk); idle_all();
    drive(1, 1'b1, 1'b0, 12'h82C, 32'h0);
    drive(2, 1'b1, 1'b0, 12'h82C, 32'h0);
    #2;
    chk(8, rdat(1), 32'h0, "pair r1 wins");
    chk(8, rdat(2), 32'h1, "pair r2 loses");
    chk(10, rdat(0), 32'h0, "idle requester reads 0");

    // R11: release of held flag 10 with concurrent read
    @(negedge clk); idle_all();
    drive(0, 1'b0, 1'b1, 12'h828, 32'h0);
    drive(1, 1'b1, 1'b0, 12'h828, 32'h0);
    #2 chk(11, rdat(1), 32'h1, "read during release sees held");
    @(negedge clk); idle_all(); drive(2, 1'b1, 1'b0, 12'h828, 32'h0);
    #2 chk(11, rdat(2), 32'h0, "flag free after release cycle");

    // R11: zero write to free flag 12 with concurrent read: reader takes it
    @(negedge clk); idle_all();
    drive(0, 1'b0, 1'b1, 12'h830, 32'h0);
    drive(1, 1'b1, 1'b0, 12'h830, 32'h0);
    #2 chk(11, rdat(1), 32'h0, "read of free flag during write");
    @(negedge clk); idle_all(); drive(2, 1'b1, 1'b0, 12'h830, 32'h0);
    #2 chk(11, rdat(2), 32'h1, "flag held after take");

    // R1: reset while flag 5 held
    @(negedge clk); idle_all(); drive(0, 1'b1, 1'b0, 12'h814, 32'h0);
    #2 chk(2, rdat(0), 32'h0, "take flag 5");
    @(negedge clk); idle_all(); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk); idle_all(); drive(1, 1'b1, 1'b0, 12'h814, 32'h0);
    #2 chk(1, rdat(1), 32'h0, "flag 5 free after reset");
    @(negedge clk); idle_all();
    #2 chk(10, rdat(1), 32'h0, "no strobe reads 0");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #500000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule